// File: doc/BRIEF.md
# BCD Real-Time Calendar with Minute Alarm

This core keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours (24-hour), day of month, weekday, month with a century flag, and a two-digit year. A free-running enable input at 32.768 kHz is divided down to a one-second step. Each counter carries into the next field one decimal digit at a time. Day-of-month rollover follows the length of the current month, and February has 29 days in any year divisible by four.

Software reaches the core through a flat synchronous register port: a 4-bit address, an 8-bit write bus with a write strobe, and a combinational read bus. A control register holds a freeze bit, so a full date can be loaded without a carry landing halfway through the load. A second control register holds the alarm flag and the alarm interrupt enable. Four alarm registers (minute, hour, day, weekday) each carry a per-field disable in bit 7. At the start of every minute the enabled fields are compared with the time, and a match latches the flag. The interrupt pin is driven low for as long as both the flag and the enable are set.

Top module: `rtc_core`

## Requirements
- R1: After reset, the registers read as follows. Seconds reads 0x80 (power-fail bit set). Minutes, hours, weekday and year read 0x00. Day and month read 0x01. Both control registers read 0x00. Every alarm register reads 0x80 (field disabled). `alarm_n` is 1.
- R2: The register addresses are as follows.
  - 0x0 control A: bit 5 is the freeze bit.
  - 0x1 control B: bit 3 is the alarm flag and bit 1 is the interrupt enable.
  - 0x2 seconds: bit 7 is the power-fail bit; the value is in bits 6:0.
  - 0x3 minutes: bits 6:0.
  - 0x4 hours: bits 5:0.
  - 0x5 day: bits 5:0.
  - 0x6 weekday: bits 2:0.
  - 0x7 month: bits 4:0, with the century flag in bit 7.
  - 0x8 year: all 8 bits.
  - 0x9 to 0xC alarm minute, hour, day and weekday: each is bit 7 plus the same value bits as the matching time field.
  - Unimplemented bits read 0, and addresses 0xD to 0xF read 0x00.
- R3: While the freeze bit is 1, the calendar does not change and the divider is held at zero. After the freeze bit is cleared, the seconds field advances once every PRESCALE pulses of `tick_en`.
- R4: Every field increments digit-wise in BCD. Seconds and minutes wrap from 59 to 00, and hours from 23 to 00. The weekday steps once per day and wraps from 6 to 0.
- R5: Day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. February ends at 28, or at 29 when the BCD year is divisible by 4 (year 00 included). The month wraps from 12 to 01.
- R6: The year wraps from 99 to 00, and on that wrap the century flag in month bit 7 toggles.
- R7: Any write to the seconds register clears the power-fail bit. Nothing else sets it except reset.
- R8: The alarm is evaluated only when seconds roll from 59 to 00. The alarm flag sets when at least one alarm field is enabled (bit 7 = 0) and every enabled field equals the new time. Seconds never take part in the comparison.
- R9: The alarm flag stays set until a write to control B with bit 3 = 0. Writing bit 3 = 1 never sets the flag.
- R10: `alarm_n` is 0 exactly while the alarm flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable pulse at the 32.768 kHz rate |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe, acts on the rising clock edge |
| rdata | output | 8 | Read data for `addr` (combinational) |
| alarm_n | output | 1 | Alarm interrupt, active low, level |

## Verification
The hardest state to reach is an alarm decision at a minute boundary that also crosses a day, month or year boundary. Reaching it from the ports needs the calendar parked a few seconds before the rollover. The bench freezes the core, loads a start time chosen near field limits, releases it, and re-freezes it after an exact number of one-second steps. With a small divider, the number of cycles that gives N steps is known precisely. Random start times are biased toward 59 seconds, 59 minutes, 23 hours, the last day of a month and year 99. Directed cases cover leap and non-leap February, the century toggle, alarm matches on day and weekday alone, and clearing the flag inside a matching minute.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
   typedef logic [7:0] bcd8_t;

   typedef enum logic [3:0] {
      REG_CTRL_A = 4'h0,
      REG_CTRL_B = 4'h1,
      REG_SEC    = 4'h2,
      REG_MIN    = 4'h3,
      REG_HOUR   = 4'h4,
      REG_DAY    = 4'h5,
      REG_WDAY   = 4'h6,
      REG_MONTH  = 4'h7,
      REG_YEAR   = 4'h8,
      REG_AMIN   = 4'h9,
      REG_AHOUR  = 4'hA,
      REG_ADAY   = 4'hB,
      REG_AWDAY  = 4'hC
   } reg_addr_e;

   localparam int ALM_FIELDS = 4;
   localparam int FREEZE_BIT = 5;
   localparam int FLAG_BIT   = 3;
   localparam int IE_BIT     = 1;

   typedef struct packed {
      bcd8_t sec;
      bcd8_t min;
      bcd8_t hour;
      bcd8_t day;
      bcd8_t wday;
      bcd8_t month;
      bcd8_t year;
      logic  century;
   } caltime_t;

   // one decimal step: low digit 9 rolls into the high digit
   function automatic bcd8_t bcd_step(bcd8_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by 4: even tens digit with units 0/4/8, odd tens with 2/6
   function automatic logic leap_bcd(bcd8_t y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic bcd8_t month_last(bcd8_t m, logic leap);
      case (m)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
`timescale 1ns/1ps
module rtc_tick_gen #(
   parameter int PRESCALE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic hold,
   output logic sec_tick
);
   if (PRESCALE < 1) begin : g_bad_prescale
      $error("rtc_tick_gen: PRESCALE must be at least 1");
   end

   if (PRESCALE == 1) begin : g_direct
      assign sec_tick = tick_en & ~hold;
   end else begin : g_count
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cnt_q <= '0;
         else if (hold)    cnt_q <= '0;
         else if (tick_en) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign sec_tick = tick_en & ~hold & (cnt_q == LAST);

      assert_hold_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
         hold |=> (cnt_q == '0));
   end
endmodule

// File: rtl/rtc_cal_counter.sv
`timescale 1ns/1ps
module rtc_cal_counter
   import rtc_cal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   output caltime_t   cal_q,
   output logic       vlow_q,
   output logic       min_start_q
);
   localparam caltime_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                      day: 8'h01, wday: 8'h00, month: 8'h01,
                                      year: 8'h00, century: 1'b0};

   caltime_t nxt;
   logic     c_min, c_hour, c_day, c_mon, c_year;
   logic     sec_wr;

   assign sec_wr = wr_en && (wr_addr == REG_SEC);

   always_comb begin
      nxt    = cal_q;
      c_min  = 1'b0;
      c_hour = 1'b0;
      c_day  = 1'b0;
      c_mon  = 1'b0;
      c_year = 1'b0;
      if (sec_tick) begin
         if (cal_q.sec == 8'h59) begin nxt.sec = 8'h00; c_min = 1'b1; end
         else nxt.sec = bcd_step(cal_q.sec) & 8'h7F;
      end
      if (c_min) begin
         if (cal_q.min == 8'h59) begin nxt.min = 8'h00; c_hour = 1'b1; end
         else nxt.min = bcd_step(cal_q.min) & 8'h7F;
      end
      if (c_hour) begin
         if (cal_q.hour == 8'h23) begin nxt.hour = 8'h00; c_day = 1'b1; end
         else nxt.hour = bcd_step(cal_q.hour) & 8'h3F;
      end
      if (c_day) begin
         nxt.wday = (cal_q.wday >= 8'h06) ? 8'h00 : cal_q.wday + 8'h01;
         if (cal_q.day == month_last(cal_q.month, leap_bcd(cal_q.year))) begin
            nxt.day = 8'h01;
            c_mon   = 1'b1;
         end else nxt.day = bcd_step(cal_q.day) & 8'h3F;
      end
      if (c_mon) begin
         if (cal_q.month == 8'h12) begin nxt.month = 8'h01; c_year = 1'b1; end
         else nxt.month = bcd_step(cal_q.month) & 8'h1F;
      end
      if (c_year) begin
         if (cal_q.year == 8'h99) begin
            nxt.year    = 8'h00;
            nxt.century = ~cal_q.century;
         end else nxt.year = bcd_step(cal_q.year);
      end
      // a register write takes priority over the carry into that field
      if (wr_en) begin
         case (wr_addr)
            REG_SEC:   nxt.sec  = {1'b0, wr_data[6:0]};
            REG_MIN:   nxt.min  = {1'b0, wr_data[6:0]};
            REG_HOUR:  nxt.hour = {2'b0, wr_data[5:0]};
            REG_DAY:   nxt.day  = {2'b0, wr_data[5:0]};
            REG_WDAY:  nxt.wday = {5'b0, wr_data[2:0]};
            REG_MONTH: begin
               nxt.month   = {3'b0, wr_data[4:0]};
               nxt.century = wr_data[7];
            end
            REG_YEAR:  nxt.year = wr_data;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_q       <= CAL_RESET;
         vlow_q      <= 1'b1;
         min_start_q <= 1'b0;
      end else begin
         cal_q       <= nxt;
         min_start_q <= c_min;
         if (sec_wr) vlow_q <= 1'b0;
      end
   end

   assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && cal_q.sec == 8'h59 && !sec_wr) |=> (cal_q.sec == 8'h00));
   assert_minute_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (min_start_q && !$past(sec_wr)) |-> (cal_q.sec == 8'h00));
   assert_vl_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sec_wr |=> !vlow_q);
   assert_vl_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !vlow_q |=> !vlow_q);
endmodule

// File: rtl/rtc_alarm_unit.sv
`timescale 1ns/1ps
module rtc_alarm_unit
   import rtc_cal_pkg::*;
#(
   parameter int NF = ALM_FIELDS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                min_start,
   input  logic [NF-1:0][7:0]  cur_time,
   input  logic                wr_en,
   input  logic [3:0]          wr_addr,
   input  logic [7:0]          wr_data,
   output logic [NF-1:0][7:0]  alm_regs,
   output logic                flag_q,
   output logic                ie_q,
   output logic                irq_n
);
   if (NF != 4) begin : g_bad_nf
      $error("rtc_alarm_unit: exactly four alarm fields are decoded");
   end

   // value masks, index 0 = minute, then hour, day, weekday
   localparam logic [3:0][7:0] FMASK = {8'h07, 8'h3F, 8'h3F, 8'h7F};

   logic [NF-1:0] en, eq;
   logic          hit, ctl_wr;

   for (genvar i = 0; i < NF; i++) begin : g_field
      localparam logic [3:0] FA = 4'(int'(REG_AMIN) + i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           alm_regs[i] <= 8'h80;
         else if (wr_en && (wr_addr == FA))    alm_regs[i] <= wr_data & (FMASK[i] | 8'h80);
      end
      assign en[i] = ~alm_regs[i][7];
      assign eq[i] = (alm_regs[i] & FMASK[i]) == (cur_time[i] & FMASK[i]);
   end

   assign hit    = (|en) && (&(eq | ~en));
   assign ctl_wr = wr_en && (wr_addr == REG_CTRL_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ie_q   <= 1'b0;
      end else begin
         if (ctl_wr) ie_q <= wr_data[IE_BIT];
         if (min_start && hit)                  flag_q <= 1'b1;
         else if (ctl_wr && !wr_data[FLAG_BIT]) flag_q <= 1'b0;
      end
   end

   assign irq_n = ~(flag_q & ie_q);

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(ctl_wr && !wr_data[FLAG_BIT])) |=> flag_q);
   assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(min_start));
   assert_no_empty_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (min_start && en == '0 && !ctl_wr) |=> $stable(flag_q));
   assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && ie_q && !ctl_wr && !min_start) |=> !irq_n);
endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core
   import rtc_cal_pkg::*;
#(
   parameter int PRESCALE = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic [3:0] addr,
   input  logic [7:0] wdata,
   input  logic       we,
   output logic [7:0] rdata,
   output logic       alarm_n
);
   caltime_t                      cal_q;
   logic                          freeze_q, sec_tick, vlow_q, min_start;
   logic [ALM_FIELDS-1:0][7:0]    alm_regs;
   logic                          flag_q, ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             freeze_q <= 1'b0;
      else if (we && addr == REG_CTRL_A)      freeze_q <= wdata[FREEZE_BIT];
   end

   rtc_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .hold(freeze_q), .sec_tick(sec_tick)
   );

   rtc_cal_counter u_cal (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .wr_en(we), .wr_addr(addr), .wr_data(wdata),
      .cal_q(cal_q), .vlow_q(vlow_q), .min_start_q(min_start)
   );

   rtc_alarm_unit #(.NF(ALM_FIELDS)) u_alarm (
      .clk(clk), .rst_n(rst_n), .min_start(min_start),
      .cur_time({cal_q.wday, cal_q.day, cal_q.hour, cal_q.min}),
      .wr_en(we), .wr_addr(addr), .wr_data(wdata),
      .alm_regs(alm_regs), .flag_q(flag_q), .ie_q(ie_q), .irq_n(alarm_n)
   );

   always_comb begin
      case (addr)
         REG_CTRL_A: rdata = 8'(freeze_q) << FREEZE_BIT;
         REG_CTRL_B: rdata = (8'(flag_q) << FLAG_BIT) | (8'(ie_q) << IE_BIT);
         REG_SEC:    rdata = cal_q.sec | {vlow_q, 7'b0};
         REG_MIN:    rdata = cal_q.min;
         REG_HOUR:   rdata = cal_q.hour;
         REG_DAY:    rdata = cal_q.day;
         REG_WDAY:   rdata = cal_q.wday;
         REG_MONTH:  rdata = cal_q.month | {cal_q.century, 7'b0};
         REG_YEAR:   rdata = cal_q.year;
         REG_AMIN:   rdata = alm_regs[0];
         REG_AHOUR:  rdata = alm_regs[1];
         REG_ADAY:   rdata = alm_regs[2];
         REG_AWDAY:  rdata = alm_regs[3];
         default:    rdata = 8'h00;
      endcase
   end

   assert_freeze_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_q && !we) |=> $stable(cal_q));
   assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_q |-> alarm_n);
endmodule

// File: tb/rtc_core_bench.sv
`timescale 1ns/1ps
module rtc_core_bench;
   localparam int PS = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic [3:0] addr = 4'h0;
   logic [7:0] wdata = 8'h00;
   logic       we = 1'b0;
   logic [7:0] rdata;
   logic       alarm_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference time in binary
   int m_sec, m_min, m_hr, m_day, m_wd, m_mon, m_yr, m_cent;

   always #2 clk = ~clk;

   rtc_core #(.PRESCALE(PS)) u_rtc_core (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
      .wdata(wdata), .we(we), .rdata(rdata), .alarm_n(alarm_n)
   );

   function automatic logic [7:0] to_bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dim(int mon, int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   task automatic model_step();
      m_sec++;
      if (m_sec == 60) begin m_sec = 0; m_min++; end
      if (m_min == 60) begin m_min = 0; m_hr++; end
      if (m_hr == 24) begin m_hr = 0; m_day++; m_wd = (m_wd + 1) % 7; end
      if (m_day > dim(m_mon, m_yr)) begin m_day = 1; m_mon++; end
      if (m_mon > 12) begin m_mon = 1; m_yr++; end
      if (m_yr > 99) begin m_yr = 0; m_cent = 1 - m_cent; end
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk);
      #1 we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic load_time(input int s, input int mi, input int h, input int d,
                            input int w, input int mo, input int y, input int c);
      wr(4'h0, 8'h20);
      wr(4'h2, to_bcd(s));
      wr(4'h3, to_bcd(mi));
      wr(4'h4, to_bcd(h));
      wr(4'h5, to_bcd(d));
      wr(4'h6, to_bcd(w));
      wr(4'h7, to_bcd(mo) | {c[0], 7'b0});
      wr(4'h8, to_bcd(y));
      m_sec = s; m_min = mi; m_hr = h; m_day = d; m_wd = w; m_mon = mo; m_yr = y; m_cent = c;
   endtask

   // release the freeze, let exactly n seconds pass, freeze again
   task automatic run_secs(input int n);
      wr(4'h0, 8'h00);
      repeat (PS * n) @(posedge clk);
      wr(4'h0, 8'h20);
      for (int k = 0; k < n; k++) model_step();
   endtask

   task automatic cmp_time(input string tag);
      logic [7:0] v;
      rd(4'h2, v); chk({tag, " sec"},   v, to_bcd(m_sec));
      rd(4'h3, v); chk({tag, " min"},   v, to_bcd(m_min));
      rd(4'h4, v); chk({tag, " hour"},  v, to_bcd(m_hr));
      rd(4'h5, v); chk({tag, " day"},   v, to_bcd(m_day));
      rd(4'h6, v); chk({tag, " wday"},  v, to_bcd(m_wd));
      rd(4'h7, v); chk({tag, " month"}, v, to_bcd(m_mon) | {m_cent[0], 7'b0});
      rd(4'h8, v); chk({tag, " year"},  v, to_bcd(m_yr));
   endtask

   task automatic set_alarm(input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] d, input logic [7:0] w, input logic [7:0] ctl);
      wr(4'h9, mi); wr(4'hA, h); wr(4'hB, d); wr(4'hC, w); wr(4'h1, ctl);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int unsigned seed_v;
      seed_v = $urandom(32'd20517);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state (read before the first second elapses)
      rd(4'h2, v); chk("R1 sec/vl", v, 8'h80);
      rd(4'h5, v); chk("R1 day", v, 8'h01);
      rd(4'h7, v); chk("R1 month", v, 8'h01);
      rd(4'h1, v); chk("R1 ctrlB", v, 8'h00);
      rd(4'h0, v); chk("R1 ctrlA", v, 8'h00);
      for (int i = 9; i <= 12; i++) begin
         rd(4'(i), v); chk("R1 alarm reg", v, 8'h80);
      end
      chk("R1 alarm_n", {7'b0, alarm_n}, 8'h01);

      // R2 field masks and unmapped addresses
      wr(4'h0, 8'hFF);
      rd(4'h0, v); chk("R2 ctrlA mask", v, 8'h20);
      wr(4'h6, 8'hFF); rd(4'h6, v); chk("R2 wday mask", v, 8'h07);
      wr(4'h4, 8'hFF); rd(4'h4, v); chk("R2 hour mask", v, 8'h3F);
      wr(4'hC, 8'h7F); rd(4'hC, v); chk("R2 alarm wday mask", v, 8'h07);
      wr(4'hC, 8'h80);
      rd(4'hD, v); chk("R2 unmapped", v, 8'h00);

      // R7 power-fail bit clears on a seconds write
      wr(4'h2, 8'h12); rd(4'h2, v); chk("R7 vl cleared", v, 8'h12);

      // R3 freeze holds the calendar
      load_time(30, 15, 8, 10, 2, 5, 21, 0);
      repeat (40) @(posedge clk);
      cmp_time("R3 frozen");
      run_secs(7);
      cmp_time("R3 exact seconds");

      // R5 leap year, non-leap, 30-day month, year 00
      load_time(59, 59, 23, 28, 1, 2, 24, 0); run_secs(1); cmp_time("R5 leap feb28");
      load_time(59, 59, 23, 29, 2, 2, 24, 0); run_secs(1); cmp_time("R5 leap feb29");
      load_time(59, 59, 23, 28, 1, 2, 23, 0); run_secs(1); cmp_time("R5 nonleap feb");
      load_time(59, 59, 23, 28, 1, 2, 0, 1);  run_secs(1); cmp_time("R5 year00 feb");
      load_time(58, 59, 23, 30, 6, 9, 10, 0); run_secs(3); cmp_time("R5 30-day month");
      load_time(59, 59, 23, 30, 6, 1, 10, 0); run_secs(1); cmp_time("R5 31-day month");

      // R6 century toggle
      load_time(59, 59, 23, 31, 6, 12, 99, 0); run_secs(1); cmp_time("R6 century up");
      load_time(57, 59, 23, 31, 3, 12, 99, 1); run_secs(4); cmp_time("R6 century down");

      // R4 random start points biased toward field limits
      for (int it = 0; it < 30; it++) begin
         int s, mi, h, d, mo, y;
         y  = ($urandom_range(3, 0) == 0) ? 99 : int'($urandom_range(99, 0));
         mo = ($urandom_range(1, 0) == 0) ? 12 : int'($urandom_range(12, 1));
         d  = ($urandom_range(1, 0) == 0) ? dim(mo, y) : int'($urandom_range(dim(mo, y), 1));
         h  = ($urandom_range(1, 0) == 0) ? 23 : int'($urandom_range(23, 0));
         mi = ($urandom_range(1, 0) == 0) ? 59 : int'($urandom_range(59, 0));
         s  = int'($urandom_range(59, 40));
         load_time(s, mi, h, d, int'($urandom_range(6, 0)), mo, y, int'($urandom_range(1, 0)));
         run_secs(int'($urandom_range(30, 1)));
         cmp_time("R4 random");
      end

      // R8 minute and hour match, day and weekday disabled
      load_time(58, 29, 10, 15, 3, 6, 24, 0);
      set_alarm(8'h30, 8'h10, 8'h80, 8'h80, 8'h02);
      run_secs(3);
      rd(4'h1, v); chk("R8 match sets flag", v, 8'h0A);
      chk("R10 irq low", {7'b0, alarm_n}, 8'h00);
      wr(4'h1, 8'h02);
      rd(4'h1, v); chk("R9 clear by 0", v, 8'h02);
      chk("R10 irq released", {7'b0, alarm_n}, 8'h01);
      run_secs(5);
      rd(4'h1, v); chk("R8 once per minute", v, 8'h02);
      wr(4'h1, 8'h0A);
      rd(4'h1, v); chk("R9 write 1 no set", v, 8'h02);

      // R8 one enabled field mismatches
      load_time(58, 30, 10, 15, 3, 6, 24, 0);
      set_alarm(8'h31, 8'h11, 8'h80, 8'h80, 8'h02);
      run_secs(3);
      rd(4'h1, v); chk("R8 hour mismatch", v, 8'h02);

      // R8 all fields disabled
      load_time(58, 59, 23, 15, 3, 6, 24, 0);
      set_alarm(8'h80, 8'h80, 8'h80, 8'h80, 8'h02);
      run_secs(3);
      rd(4'h1, v); chk("R8 none enabled", v, 8'h02);

      // R10 flag with enable off, then enable on
      load_time(58, 31, 10, 15, 3, 6, 24, 0);
      set_alarm(8'h32, 8'h80, 8'h80, 8'h80, 8'h00);
      run_secs(3);
      rd(4'h1, v); chk("R10 flag without enable", v, 8'h08);
      chk("R10 irq high when disabled", {7'b0, alarm_n}, 8'h01);
      wr(4'h1, 8'h0A);
      rd(4'h1, v); chk("R9 flag kept by writing 1", v, 8'h0A);
      chk("R10 irq low when enabled", {7'b0, alarm_n}, 8'h00);
      wr(4'h1, 8'h00);

      // R8 day and weekday match across midnight
      load_time(58, 59, 23, 14, 2, 6, 24, 0);
      set_alarm(8'h80, 8'h80, 8'h15, 8'h03, 8'h02);
      run_secs(3);
      cmp_time("R4 midnight");
      rd(4'h1, v); chk("R8 day+wday match", v, 8'h0A);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule